// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single-digit synchronous counter that walks through the decimal codes 0 to 9 in either direction. On each rising clock edge it either takes a parallel value, steps one place up or down, or holds. A direction pin chooses the way it counts. An active-low enable gates the stepping, and an active-low load gates the parallel copy.

Two outputs let several digits form a wider decimal counter. A limit flag rises whenever the digit sits at the end of its range for the chosen direction. An active-low ripple pulse goes low during the low half of the clock when that limit coincides with an active enable. A following digit takes either signal as its own enable. Codes 10 to 15 can only enter through the load, and the first count step after such a load returns the digit to the legal range.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0.
- R2: With `load_n`=1, `cnt_en_n`=0 and `dir_down`=0, each rising edge adds one to a count of 0 to 8, and a count of 9 becomes 0.
- R3: With `load_n`=1, `cnt_en_n`=0 and `dir_down`=1, each rising edge subtracts one from a count of 1 to 9, and a count of 0 becomes 9.
- R4: With `load_n`=1 and `cnt_en_n`=1, the count holds its value across rising edges in either direction.
- R5: With `load_n`=0, the rising edge copies `load_val` into the count, whatever `cnt_en_n` and `dir_down` are, and values 10 to 15 are copied as well.
- R6: From a count of 10 to 15, one enabled up step gives 0 and one enabled down step gives 9.
- R7: `max_min` is 1 exactly when the count is 9 with `dir_down`=0, or 0 with `dir_down`=1. It follows the count and direction within the same cycle and does not depend on `cnt_en_n`.
- R8: `ripple_n` is 0 only while `clk` is low, `cnt_en_n` is 0 and `max_min` is 1. At all other times it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load strobe |
| load_val | input | 4 | Value copied in on a load |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| count | output | 4 | Present BCD digit |
| max_min | output | 1 | End of range for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during the low clock half |

## Verification
The assertions check every edge for the one-step rules. These are the increment, the decrement and both wraps, holding when disabled, the loaded value and its priority, the return from codes 10 to 15, and that a legal digit stays legal. The shape of `ripple_n` within a clock period is not visible to an edge-sampled property. The bench therefore samples it in both clock halves. The bench also walks full up and down sequences, reverses direction in mid-count, and loads illegal codes, which shows that the sequence as a whole follows the requirements.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    localparam int DIGIT_TOP = 9;
    localparam int DIGIT_W   = $clog2(DIGIT_TOP + 1);

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Active-high view of the control pins
    typedef struct packed {
        logic   load;
        logic   step;
        dir_e   dir;
        digit_t data;
    } ctl_t;

    // Upward step; anything at or above the top returns to zero
    function automatic digit_t step_up(digit_t d);
        return (d >= digit_t'(DIGIT_TOP)) ? '0 : d + digit_t'(1);
    endfunction

    // Downward step; zero and any illegal code return to the top
    function automatic digit_t step_down(digit_t d);
        return (d == '0 || d > digit_t'(DIGIT_TOP)) ? digit_t'(DIGIT_TOP)
                                                    : d - digit_t'(1);
    endfunction

endpackage

// File: rtl/bcd_ctl_decode.sv
module bcd_ctl_decode
    import bcd_ctr_pkg::*;
(
    input  logic   load_n,
    input  digit_t load_val,
    input  logic   cnt_en_n,
    input  logic   dir_down,
    output ctl_t   ctl
);
    always_comb begin
        ctl.load = ~load_n;
        ctl.step = ~cnt_en_n;
        ctl.dir  = dir_down ? DIR_DOWN : DIR_UP;
        ctl.data = load_val;
    end
endmodule

// File: rtl/bcd_next.sv
module bcd_next
    import bcd_ctr_pkg::*;
(
    input  ctl_t   ctl,
    input  digit_t cur,
    output digit_t nxt
);
    always_comb begin
        if (ctl.load)
            nxt = ctl.data;
        else if (ctl.step)
            nxt = (ctl.dir == DIR_DOWN) ? step_down(cur) : step_up(cur);
        else
            nxt = cur;
    end
endmodule

// File: rtl/bcd_term_gate.sv
module bcd_term_gate
    import bcd_ctr_pkg::*;
(
    input  logic   clk,
    input  ctl_t   ctl,
    input  digit_t cur,
    output logic   at_limit,
    output logic   ripple_n
);
    always_comb begin
        if (ctl.dir == DIR_DOWN)
            at_limit = (cur == '0);
        else
            at_limit = (cur == digit_t'(DIGIT_TOP));
        ripple_n = ~(ctl.step & at_limit & ~clk);
    end
endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
    import bcd_ctr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               cnt_en_n,
    input  logic               dir_down,
    output logic [DIGIT_W-1:0] count,
    output logic               max_min,
    output logic               ripple_n
);
    ctl_t   ctl;
    digit_t cur_q;
    digit_t nxt;

    bcd_ctl_decode u_decode (
        .load_n   (load_n),
        .load_val (load_val),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .ctl      (ctl)
    );

    bcd_next u_next (
        .ctl (ctl),
        .cur (cur_q),
        .nxt (nxt)
    );

    bcd_term_gate u_term (
        .clk      (clk),
        .ctl      (ctl),
        .cur      (cur_q),
        .at_limit (max_min),
        .ripple_n (ripple_n)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign count = cur_q;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_down && count < digit_t'(DIGIT_TOP))
        |=> count == $past(count) + digit_t'(1)); // R2

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_down && count == digit_t'(DIGIT_TOP))
        |=> count == '0); // R2

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_down && count != '0 && count <= digit_t'(DIGIT_TOP))
        |=> count == $past(count) - digit_t'(1)); // R3

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_down && count == '0)
        |=> count == digit_t'(DIGIT_TOP)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> $stable(count)); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> count == $past(load_val)); // R5

    AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && count > digit_t'(DIGIT_TOP))
        |=> count == (dir_down ? digit_t'(DIGIT_TOP) : '0) || $past(dir_down) != dir_down
            ? count == ($past(dir_down) ? digit_t'(DIGIT_TOP) : '0) : 1'b0); // R6

    AST_STAY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (load_n && count <= digit_t'(DIGIT_TOP)) |=> count <= digit_t'(DIGIT_TOP)); // R2
endmodule

// File: tb/bcd_updown_ctr_bench.sv
module bcd_updown_ctr_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic [3:0] count;
    logic       max_min;
    logic       ripple_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] mdl = 4'd0;

    always #4 clk = ~clk;

    bcd_updown_ctr u_bcd_updown_ctr (
        .clk(clk), .rst(rst), .load_n(load_n), .load_val(load_val),
        .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .count(count), .max_min(max_min), .ripple_n(ripple_n)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, check the combinational flags in the low half,
    // and queue the count expected after the coming rising edge.
    task automatic step(bit r, bit ld_n, logic [3:0] v, bit en_n, bit dn, string tag);
        bit exp_flag;
        @(negedge clk);
        rst = r; load_n = ld_n; load_val = v; cnt_en_n = en_n; dir_down = dn;
        #1;
        if (!r) begin
            exp_flag = dn ? (mdl == 4'd0) : (mdl == 4'd9);
            check("R7 max_min", max_min, exp_flag);
            check("R8 ripple_n low half", ripple_n, !(exp_flag && !en_n));
        end
        if (r)          mdl = 4'd0;
        else if (!ld_n) mdl = v;
        else if (!en_n) begin
            if (dn) mdl = (mdl == 4'd0 || mdl > 4'd9) ? 4'd9 : mdl - 4'd1;
            else    mdl = (mdl >= 4'd9) ? 4'd0 : mdl + 4'd1;
        end
        exp_q.push_back(mdl);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the count and the high-half ripple level
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, count, e);
                check("R8 ripple_n high half", ripple_n, 1);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(1, 1, 4'd5, 0, 0, "R1 reset");
        step(1, 0, 4'd7, 0, 1, "R1 reset over load");
        // R2: up through wrap
        for (int i = 0; i < 12; i++) step(0, 1, 4'd0, 0, 0, "R2 up");
        // R4: hold in both directions
        for (int i = 0; i < 3; i++) step(0, 1, 4'd0, 1, 0, "R4 hold up");
        for (int i = 0; i < 3; i++) step(0, 1, 4'd0, 1, 1, "R4 hold down");
        // R3: down through wrap
        for (int i = 0; i < 12; i++) step(0, 1, 4'd0, 0, 1, "R3 down");
        // Reverse direction mid count
        step(0, 0, 4'd4, 1, 0, "R5 load idle");
        step(0, 1, 4'd0, 0, 0, "R2 up after load");
        step(0, 1, 4'd0, 0, 1, "R3 reversed");
        step(0, 1, 4'd0, 0, 1, "R3 reversed");
        // R5: load beats an enabled count
        step(0, 0, 4'd9, 0, 1, "R5 load over count");
        step(0, 0, 4'd0, 0, 0, "R5 load over count");
        // Limit reached with enable off: flag only
        step(0, 0, 4'd9, 1, 0, "R5 load 9");
        step(0, 1, 4'd0, 1, 0, "R4 hold at 9");
        step(0, 1, 4'd0, 0, 0, "R2 wrap to 0");
        // R6: illegal codes
        step(0, 0, 4'd12, 1, 0, "R5 load 12");
        step(0, 1, 4'd0, 0, 0, "R6 12 up");
        step(0, 0, 4'd15, 0, 1, "R5 load 15");
        step(0, 1, 4'd0, 0, 1, "R6 15 down");
        step(0, 0, 4'd10, 0, 0, "R5 load 10");
        step(0, 1, 4'd0, 1, 1, "R4 hold illegal");
        step(0, 1, 4'd0, 0, 1, "R6 10 down");
        step(0, 0, 4'd14, 0, 0, "R5 load 14");
        step(0, 1, 4'd0, 0, 0, "R6 14 up");
        @(negedge clk);
        cnt_en_n = 1'b1; load_n = 1'b1;
        @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule